// File: doc/BRIEF.md
# Privileged Instruction Permission Checker

This block decides, for each privileged or configuration-sensitive instruction class, whether the decoder must raise an illegal-instruction exception or a virtual-instruction exception. It serves a core with a hypervisor extension and five privilege modes: machine (M), hypervisor-supervisor (HS), host user (HU), virtual supervisor (VS) and virtual user (VU). It also decides when a cache-block invalidate must be carried out as a flush.

The controlling fields are the trap-virtual-memory, timeout-wait and hypervisor-user bits, the floating-point and vector state fields, the dynamic rounding mode, and the cache-block enables of the machine, hypervisor and supervisor environment levels. They sit in registers that a simple write port loads. Every output flag is combinational from those registers and from the current privilege mode input. The decoder samples the flags while it decodes. Instruction decoding and trap entry are done elsewhere.

Top module: `priv_guard`

## Requirements
- R1: After reset every configuration field is zero. The floating-point and vector state are therefore Off, the rounding mode is 0, every cache-block enable is clear and every invalidate field is Off.
- R2: The privilege mode comes from `priv_lvl` and `priv_virt`. Level 3 and level 2 both mean M, and `priv_virt` is ignored for them. Level 1 means HS, or VS when `priv_virt` is 1. Level 0 means HU, or VU when `priv_virt` is 1.
- R3: When `cfg_we` is 1, the register picked by `cfg_sel` is loaded at the clock edge, and the outputs follow from the next cycle. Select 0 is the status word: bit0 TVM, bit1 TW, bit2 VTVM, bit3 VTW, bit4 HU, bits6:5 FS, bits8:7 VS, bits11:9 rounding mode. Selects 1, 2 and 3 are the machine, hypervisor and supervisor environment words: bit0 zero-enable, bit1 clean/flush-enable, bits3:2 invalidate field. Other data bits, and any write with `cfg_we` at 0, have no effect.
- R4: Address-translation fence, `ill_o[0]`: illegal in HU, and in HS when TVM is 1. It is virtual (`virt_o[0]`) in VU, and in VS when VTVM is 1. Partial fence, `ill_o[1]` and `virt_o[1]`: illegal only in HU and virtual only in VU.
- R5: Guest-physical hypervisor fence, `ill_o[2]`: illegal under the same condition as the address-translation fence. Virtual-address hypervisor fence, `ill_o[3]`: illegal only in HU. Both hypervisor fences are virtual (`virt_o[2]`) in VS and VU.
- R6: Hypervisor load/store, `ill_o[4]`: illegal in HU when the HU bit is 0. It is virtual (`virt_o[3]`) in VS and VU.
- R7: Wait-for-interrupt, `ill_o[5]`: illegal in HU, and in any mode other than M when TW is 1. It is virtual (`virt_o[4]`) in VU when TW is 0, and in VS when TW is 0 and VTW is 1.
- R8: `ill_o[6]` is set when FS is 0 (Off). `ill_o[7]` is set when VS is 0 (Off). `ill_o[8]` is set when the rounding mode is greater than 4. None of the three depends on the mode.
- R9: Cache-block zero (index 0) and clean/flush (index 1) each use their own enable bit. The class is illegal (`ill_o[9]` for zero, `ill_o[10]` for clean/flush) when the mode is not M and the machine enable is clear, or when the mode is HU and the supervisor enable is clear. It is virtual (`virt_o[5]` for zero, `virt_o[6]` for clean/flush) when the machine enable is set and either the mode is VS with the hypervisor enable clear, or the mode is VU with the hypervisor or supervisor enable clear.
- R10: The invalidate field encodes 00 as Off, 01 as Flush and 11 as Invalidate. The value 10 is treated as Off. Cache-block invalidate (`ill_o[11]`, `virt_o[7]`) follows the R9 rules, with "Off" taking the place of "clear".
- R11: `inval_flush_o` is 1 when a level that applies to the mode has its invalidate field at Flush. In HS only the machine level applies. In HU the machine and supervisor levels apply. In VS the machine and hypervisor levels apply. In VU all three apply. In M the output is 0.
- R12: In M mode, no class is illegal or virtual and `inval_flush_o` is 0, except for the mode-independent flags of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the configuration registers |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Selects the register to write: status, or the machine, hypervisor or supervisor environment word |
| cfg_wdata | input | DATA_W | Write data |
| priv_lvl | input | 2 | Privilege level of the instruction being decoded |
| priv_virt | input | 1 | Virtualization bit |
| ill_o | output | 12 | Illegal-instruction flags, one per class |
| virt_o | output | 8 | Virtual-instruction flags, one per class |
| inval_flush_o | output | 1 | Perform cache-block invalidate as a flush |

## Verification
Directed vectors cover two cases. The first is the reserved level 2 set against level 3, which shows whether the mode decode folds level 2 into M. The second puts one enable or field at a time against each mode, which shows whether the conditions attach to the right level. Random vectors load random status and environment words, including the reserved invalidate code 10 and rounding modes around 4. After each load, every privilege level is applied with both values of the virtualization bit, so that illegal and virtual outcomes for the same class are told apart in every mode. Writes with the enable low check that held state stays unchanged.

// File: rtl/priv_guard_pkg.sv
package priv_guard_pkg;

    typedef enum logic [2:0] {
        MODE_M  = 3'd0,
        MODE_HS = 3'd1,
        MODE_HU = 3'd2,
        MODE_VS = 3'd3,
        MODE_VU = 3'd4
    } mode_e;

    typedef struct packed {
        logic       tvm;
        logic       tw;
        logic       vtvm;
        logic       vtw;
        logic       hu;
        logic [1:0] fs;
        logic [1:0] vs;
        logic [2:0] frm;
    } stat_t;

    typedef struct packed {
        logic       zero_en;
        logic       clean_en;
        logic [1:0] inval;
    } env_t;

    localparam int NUM_LVL  = 3;
    localparam int LVL_M    = 0;
    localparam int LVL_H    = 1;
    localparam int LVL_S    = 2;
    localparam int NUM_ILL  = 12;
    localparam int NUM_VIRT = 8;
    localparam int STAT_W   = 12;
    localparam int ENV_W    = 4;

    typedef struct packed {
        stat_t                    st;
        env_t [NUM_LVL-1:0]       env;
    } cfg_t;

    // Off is 00 or the reserved 10: low bit clear
    function automatic logic inval_off(input logic [1:0] f);
        return ~f[0];
    endfunction

    function automatic logic inval_flush(input logic [1:0] f);
        return f == 2'b01;
    endfunction

endpackage

// File: rtl/priv_guard_cfg.sv
module priv_guard_cfg
    import priv_guard_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg_o
);
    cfg_t       cfg_d;
    cfg_t       cfg_q;
    logic [1:0] lvl_idx;

    assign lvl_idx = sel - 2'd1;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (sel == 2'd0) begin
                cfg_d.st.tvm  = wdata[0];
                cfg_d.st.tw   = wdata[1];
                cfg_d.st.vtvm = wdata[2];
                cfg_d.st.vtw  = wdata[3];
                cfg_d.st.hu   = wdata[4];
                cfg_d.st.fs   = wdata[6:5];
                cfg_d.st.vs   = wdata[8:7];
                cfg_d.st.frm  = wdata[11:9];
            end else begin
                cfg_d.env[lvl_idx].zero_en  = wdata[0];
                cfg_d.env[lvl_idx].clean_en = wdata[1];
                cfg_d.env[lvl_idx].inval    = wdata[3:2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/priv_guard_sys.sv
module priv_guard_sys
    import priv_guard_pkg::*;
(
    input  mode_e mode,
    input  stat_t st,
    output logic  ill_sfence,
    output logic  ill_spart,
    output logic  ill_hgvma,
    output logic  ill_hvvma,
    output logic  ill_hls,
    output logic  ill_wfi,
    output logic  ill_fp,
    output logic  ill_vec,
    output logic  frm_rsv,
    output logic  vi_sfence,
    output logic  vi_spart,
    output logic  vi_hfence,
    output logic  vi_hls,
    output logic  vi_wfi
);
    logic is_m, is_hs, is_hu, is_vs, is_vu, is_guest;

    always_comb begin
        is_m     = (mode == MODE_M);
        is_hs    = (mode == MODE_HS);
        is_hu    = (mode == MODE_HU);
        is_vs    = (mode == MODE_VS);
        is_vu    = (mode == MODE_VU);
        is_guest = is_vs | is_vu;

        ill_sfence = is_hu | (is_hs & st.tvm);
        ill_spart  = is_hu;
        ill_hgvma  = ill_sfence;
        ill_hvvma  = is_hu;
        ill_hls    = is_hu & ~st.hu;
        ill_wfi    = is_hu | (~is_m & st.tw);
        ill_fp     = (st.fs == 2'b00);
        ill_vec    = (st.vs == 2'b00);
        frm_rsv    = (st.frm > 3'd4);

        vi_sfence  = is_vu | (is_vs & st.vtvm);
        vi_spart   = is_vu;
        vi_hfence  = is_guest;
        vi_hls     = is_guest;
        vi_wfi     = ~st.tw & (is_vu | (is_vs & st.vtw));
    end

endmodule

// File: rtl/priv_guard_cbo.sv
module priv_guard_cbo
    import priv_guard_pkg::*;
(
    input  mode_e              mode,
    input  env_t [NUM_LVL-1:0] env,
    output logic [2:0]         ill_o,
    output logic [2:0]         virt_o,
    output logic               flush_o
);
    logic is_m, is_hs, is_hu, is_vs, is_vu;
    logic off_m, off_h, off_s, fl_m, fl_h, fl_s;

    assign is_m  = (mode == MODE_M);
    assign is_hs = (mode == MODE_HS);
    assign is_hu = (mode == MODE_HU);
    assign is_vs = (mode == MODE_VS);
    assign is_vu = (mode == MODE_VU);

    function automatic logic pick_en(input env_t e, input int k);
        return (k == 0) ? e.zero_en : e.clean_en;
    endfunction

    // index 0: zero, index 1: clean/flush, each with its own enable bit
    for (genvar k = 0; k < 2; k++) begin : g_en_class
        logic en_m, en_h, en_s;
        assign en_m = pick_en(env[LVL_M], k);
        assign en_h = pick_en(env[LVL_H], k);
        assign en_s = pick_en(env[LVL_S], k);
        assign ill_o[k]  = (~is_m & ~en_m) | (is_hu & ~en_s);
        assign virt_o[k] = en_m & ((is_vs & ~en_h) | (is_vu & (~en_h | ~en_s)));
    end

    assign off_m = inval_off(env[LVL_M].inval);
    assign off_h = inval_off(env[LVL_H].inval);
    assign off_s = inval_off(env[LVL_S].inval);
    assign fl_m  = inval_flush(env[LVL_M].inval);
    assign fl_h  = inval_flush(env[LVL_H].inval);
    assign fl_s  = inval_flush(env[LVL_S].inval);

    assign ill_o[2]  = (~is_m & off_m) | (is_hu & off_s);
    assign virt_o[2] = ~off_m & ((is_vs & off_h) | (is_vu & (off_h | off_s)));
    assign flush_o   = (is_hs & fl_m)
                     | (is_hu & (fl_m | fl_s))
                     | (is_vs & (fl_m | fl_h))
                     | (is_vu & (fl_m | fl_h | fl_s));

endmodule

// File: rtl/priv_guard.sv
module priv_guard
    import priv_guard_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic [1:0]          priv_lvl,
    input  logic                priv_virt,
    output logic [NUM_ILL-1:0]  ill_o,
    output logic [NUM_VIRT-1:0] virt_o,
    output logic                inval_flush_o
);
    cfg_t       cfg;
    mode_e      mode;
    logic [2:0] cbo_ill, cbo_virt;

    always_comb begin
        unique case (priv_lvl)
            2'd1:    mode = priv_virt ? MODE_VS : MODE_HS;
            2'd0:    mode = priv_virt ? MODE_VU : MODE_HU;
            default: mode = MODE_M;
        endcase
    end

    priv_guard_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg_o (cfg)
    );

    priv_guard_sys u_sys (
        .mode       (mode),
        .st         (cfg.st),
        .ill_sfence (ill_o[0]),
        .ill_spart  (ill_o[1]),
        .ill_hgvma  (ill_o[2]),
        .ill_hvvma  (ill_o[3]),
        .ill_hls    (ill_o[4]),
        .ill_wfi    (ill_o[5]),
        .ill_fp     (ill_o[6]),
        .ill_vec    (ill_o[7]),
        .frm_rsv    (ill_o[8]),
        .vi_sfence  (virt_o[0]),
        .vi_spart   (virt_o[1]),
        .vi_hfence  (virt_o[2]),
        .vi_hls     (virt_o[3]),
        .vi_wfi     (virt_o[4])
    );

    priv_guard_cbo u_cbo (
        .mode    (mode),
        .env     (cfg.env),
        .ill_o   (cbo_ill),
        .virt_o  (cbo_virt),
        .flush_o (inval_flush_o)
    );

    assign ill_o[11:9]  = cbo_ill;
    assign virt_o[7:5]  = cbo_virt;

    // R12
    m_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_lvl[1] |-> (ill_o[5:0] == '0 && ill_o[11:9] == '0 && virt_o == '0 && !inval_flush_o));

    // R7
    wfi_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ill_o[5] && virt_o[4]));

    // R10
    inval_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ill_o[11] && virt_o[7]));

    // R3
    frm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd0) |=> (ill_o[8] == ($past(cfg_wdata[11:9]) > 3'd4)));

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_we) && $stable(priv_lvl) && $stable(priv_virt))
            |-> ($stable(ill_o) && $stable(virt_o) && $stable(inval_flush_o)));

endmodule

// File: tb/priv_guard_test.sv
`timescale 1ns/1ps
module priv_guard_test;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = '0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic [1:0]        priv_lvl = '0;
    logic              priv_virt = 1'b0;
    logic [11:0]       ill_o;
    logic [7:0]        virt_o;
    logic              inval_flush_o;

    int vectors = 0;
    int fails = 0;

    // shadow configuration
    logic tvm, tw, vtvm, vtw, hu;
    logic [1:0] fs, vs;
    logic [2:0] frm;
    logic ze [3];
    logic ce [3];
    logic [1:0] ci [3];

    always #5 clk = ~clk;

    priv_guard #(.DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .priv_lvl(priv_lvl), .priv_virt(priv_virt),
        .ill_o(ill_o), .virt_o(virt_o), .inval_flush_o(inval_flush_o)
    );

    task automatic shadow_clear();
        {tvm, tw, vtvm, vtw, hu} = '0;
        fs = '0; vs = '0; frm = '0;
        for (int i = 0; i < 3; i++) begin ze[i] = 0; ce[i] = 0; ci[i] = 2'b00; end
    endtask

    function automatic logic coff(input logic [1:0] f);
        return !(f == 2'b01 || f == 2'b11);
    endfunction

    // returns {flush, virt[7:0], ill[11:0]}
    function automatic logic [20:0] model(input logic [1:0] lvl, input logic v);
        logic m, hs, hum, vsm, vu;
        logic [11:0] ei;
        logic [7:0]  ev;
        logic        ef;
        m   = (lvl >= 2);
        hs  = (lvl == 1) && !v;
        vsm = (lvl == 1) && v;
        hum = (lvl == 0) && !v;
        vu  = (lvl == 0) && v;
        ei[0]  = hum || (hs && tvm);
        ei[1]  = hum;
        ei[2]  = hum || (hs && tvm);
        ei[3]  = hum;
        ei[4]  = hum && !hu;
        ei[5]  = hum || (!m && tw);
        ei[6]  = (fs == 0);
        ei[7]  = (vs == 0);
        ei[8]  = (frm > 4);
        ei[9]  = (!m && !ze[0]) || (hum && !ze[2]);
        ei[10] = (!m && !ce[0]) || (hum && !ce[2]);
        ei[11] = (!m && coff(ci[0])) || (hum && coff(ci[2]));
        ev[0]  = vu || (vsm && vtvm);
        ev[1]  = vu;
        ev[2]  = vu || vsm;
        ev[3]  = vu || vsm;
        ev[4]  = (vu && !tw) || (vsm && !tw && vtw);
        ev[5]  = ze[0] && ((vsm && !ze[1]) || (vu && (!ze[1] || !ze[2])));
        ev[6]  = ce[0] && ((vsm && !ce[1]) || (vu && (!ce[1] || !ce[2])));
        ev[7]  = !coff(ci[0]) && ((vsm && coff(ci[1])) || (vu && (coff(ci[1]) || coff(ci[2]))));
        ef = (hs && ci[0] == 2'b01)
          || (hum && (ci[0] == 2'b01 || ci[2] == 2'b01))
          || (vsm && (ci[0] == 2'b01 || ci[1] == 2'b01))
          || (vu && (ci[0] == 2'b01 || ci[1] == 2'b01 || ci[2] == 2'b01));
        return {ef, ev, ei};
    endfunction

    function automatic string ill_req(input int b);
        case (b)
            0, 1:    return "R4";
            2, 3:    return "R5";
            4:       return "R6";
            5:       return "R7";
            6, 7, 8: return "R8";
            9, 10:   return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic string virt_req(input int b);
        case (b)
            0, 1:    return "R4";
            2:       return "R5";
            3:       return "R6";
            4:       return "R7";
            5, 6:    return "R9";
            default: return "R10";
        endcase
    endfunction

    // applies mode, waits, compares every output bit
    task automatic check(input logic [1:0] lvl, input logic v, input string ctx);
        logic [20:0] exp_v;
        logic [20:0] act;
        priv_lvl = lvl;
        priv_virt = v;
        #1;
        exp_v = model(lvl, v);
        act = {inval_flush_o, virt_o, ill_o};
        vectors++;
        if (act !== exp_v) begin
            fails++;
            for (int b = 0; b < 12; b++)
                if (act[b] !== exp_v[b])
                    $display("FAIL %s ill[%0d] (%s) lvl=%0d virt=%0b actual=%b expected=%b",
                             ill_req(b), b, ctx, lvl, v, act[b], exp_v[b]);
            for (int b = 0; b < 8; b++)
                if (act[12+b] !== exp_v[12+b])
                    $display("FAIL %s virt[%0d] (%s) lvl=%0d virt=%0b actual=%b expected=%b",
                             virt_req(b), b, ctx, lvl, v, act[12+b], exp_v[12+b]);
            if (act[20] !== exp_v[20])
                $display("FAIL R11 flush (%s) lvl=%0d virt=%0b actual=%b expected=%b",
                         ctx, lvl, v, act[20], exp_v[20]);
        end
    endtask

    task automatic check_all_modes(input string ctx);
        for (int l = 0; l < 4; l++)
            for (int v = 0; v < 2; v++)
                check(l[1:0], v[0], ctx);
    endtask

    // R3: write lands at the edge, outputs follow from next cycle
    task automatic wr(input logic [1:0] sel, input logic [DATA_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_wdata = ~d;
        if (sel == 0) begin
            tvm = d[0]; tw = d[1]; vtvm = d[2]; vtw = d[3]; hu = d[4];
            fs = d[6:5]; vs = d[8:7]; frm = d[11:9];
        end else begin
            ze[sel-1] = d[0]; ce[sel-1] = d[1]; ci[sel-1] = d[3:2];
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        shadow_clear();
        repeat (3) @(negedge clk);
        // R1 reset state
        check_all_modes("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check_all_modes("R1 after release");

        // R2 reserved level 2 behaves as M, virt ignored
        wr(2'd0, 16'h0_06_3);  // tvm, tw, fs nonzero
        check(2'd2, 1'b1, "R2 level2 virt");
        check(2'd3, 1'b1, "R12 level3 virt");

        // R4 R5 TVM/VTVM per mode
        wr(2'd0, 16'h0025);    // tvm, vtvm, fs=01
        check_all_modes("R4 R5 tvm vtvm");
        // R6 hu bit
        wr(2'd0, 16'h0030);
        check_all_modes("R6 hu set");
        // R7 wfi: tw=0 vtw=1, then tw=1
        wr(2'd0, 16'h0008);
        check_all_modes("R7 vtw only");
        wr(2'd0, 16'h000A);
        check_all_modes("R7 tw and vtw");
        // R8 rounding modes 4 and 5
        wr(2'd0, 16'h09A0);
        check_all_modes("R8 frm 4");
        wr(2'd0, 16'h0BA0);
        check_all_modes("R8 frm 5");
        // R9 zero enable only at M level
        wr(2'd1, 16'h0001);
        check_all_modes("R9 m zero only");
        wr(2'd2, 16'h0002);
        check_all_modes("R9 h clean only");
        // R10 reserved 10 acts as Off; R11 flush per level
        wr(2'd1, 16'h0008);
        check_all_modes("R10 m reserved");
        wr(2'd1, 16'h000C);
        wr(2'd2, 16'h0004);
        check_all_modes("R11 h flush");
        wr(2'd3, 16'h0004);
        check_all_modes("R11 s flush");
        wr(2'd1, 16'h0004);
        check_all_modes("R11 m flush");

        // R3 write with enable low is ignored
        @(negedge clk);
        cfg_sel = 2'd0; cfg_wdata = 16'hFFFF;
        @(negedge clk);
        check_all_modes("R3 we low ignored");

        // random
        for (int it = 0; it < 3000; it++) begin
            if ($urandom_range(0, 1) == 1)
                wr($urandom_range(0, 3), DATA_W'($urandom));
            else
                @(negedge clk);
            for (int k = 0; k < 3; k++)
                check($urandom_range(0, 3), $urandom_range(0, 1), "random R12 R2");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule